// File: doc/BRIEF.md
# Conversion Start and Power-Down Sequencer

This block decides when a sampling converter holds its input, how long the conversion runs, and whether the analogue core sleeps afterwards. A conversion is requested either by a falling edge on the active-low convert pin or by a one-cycle software start strobe. The block then holds the track/hold for a fixed number of system-clock cycles. In the last of those cycles it captures the converter's data word, which the analogue model presents as valid at that point. It then raises a one-cycle completion pulse.

When a conversion ends, the block reads the synchronised level of the convert pin and the software sleep bit. If the pin is still low, or the sleep bit is set, the analogue core powers down. Otherwise the block returns to idle with power applied. A sleeping core wakes once the pin is high and the sleep bit is clear, and it must then wait a fixed power-up interval before it accepts another start. The block never queues a start request: any request that arrives while it is busy is dropped. The on-chip reference is powered only while the core is powered and the external-reference select is low.

The state machine has four states:
- `ST_IDLE`: powered and ready.
- `ST_CONV`: track/hold in hold, conversion timer running.
- `ST_SLEEP`: core powered down.
- `ST_WAKE`: powered, power-up timer running.

The transitions are:
- start: `ST_IDLE` to `ST_CONV`.
- end-stay: `ST_CONV` to `ST_IDLE`.
- end-sleep: `ST_CONV` to `ST_SLEEP`.
- wake: `ST_SLEEP` to `ST_WAKE`.
- warm: `ST_WAKE` to `ST_IDLE`.

Top module: `conv_sequencer`

## Requirements
- R1: During and after reset the block is in `ST_IDLE`. In that state `ready`=1, `busy`=0, `core_pwr`=1, `hold_en`=0, `done`=0 and `result`=0.
- R2: Suppose the first rising clock edge to sample `cnv_n` low is edge k, and the block is idle. Then `hold_en` is 0 after edge k+1 and becomes 1 after edge k+2, because the pin passes through SYNC_STAGES=2 synchroniser flops and one edge flop.
- R3: A `sw_start` pulse sampled high at edge k while idle sets `hold_en` after edge k.
- R4: `hold_en` stays high for exactly CONV_CYCLES clock cycles. On the edge that ends it, `done` rises for one cycle and `result` takes the value `adc_data` had in the last held cycle.
- R5: `result` changes only on a cycle where `done` is high.
- R6: A start request (pin fall or `sw_start`) is ignored while in `ST_CONV`, `ST_SLEEP` or `ST_WAKE`. It produces no extra conversion and no extra `done`, and it does not change the conversion timing.
- R7: If the synchronised pin is low in the last conversion cycle, `core_pwr` is 0 from the `done` cycle onward.
- R8: If `sw_sleep` is 1 in the last conversion cycle, the core also sleeps. If the pin is high and `sw_sleep` is 0, the block returns to `ST_IDLE` with `core_pwr`=1.
- R9: In `ST_SLEEP`, a high synchronised pin together with `sw_sleep`=0 moves the block to `ST_WAKE`. For a pin release first sampled at edge k, this happens at edge k+2. For a `sw_sleep` clear first sampled at edge k with the pin already high, it happens at edge k. `core_pwr` and `busy` are 1 in `ST_WAKE`, and `ready` returns PWRUP_CYCLES cycles later.
- R10: `intref_pwr` is 1 exactly when `core_pwr` is 1 and `ext_ref_sel` is 0.
- R11: `sw_sleep` has no effect outside the last conversion cycle and `ST_SLEEP`. While idle with `sw_sleep`=1, `core_pwr` and `ready` stay 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv_n | input | 1 | Convert pin; falling edge starts, low level at end selects sleep |
| sw_start | input | 1 | Software convert-start strobe |
| sw_sleep | input | 1 | Software power-down bit |
| ext_ref_sel | input | 1 | External reference selected; gates the on-chip reference off |
| adc_data | input | DATA_W | Converter word, valid in the last conversion cycle |
| hold_en | output | 1 | Track/hold in hold mode |
| core_pwr | output | 1 | Analogue core powered |
| intref_pwr | output | 1 | On-chip reference powered |
| busy | output | 1 | Converting, sleeping or waking |
| ready | output | 1 | Idle and able to accept a start |
| done | output | 1 | One-cycle end-of-conversion pulse |
| result | output | DATA_W | Last captured conversion word |

## Verification
Each result has a known due cycle:
- A software start shows `hold_en` one edge after the strobe, and a pin fall shows it three edges after the drive.
- `done` and the new `result` appear CONV_CYCLES edges after hold begins.
- `core_pwr` follows `done` on the same edge when the core sleeps.
- `ready` returns PWRUP_CYCLES edges after the wake edge.

The bench keeps a free-running cycle count. Each driver records the due cycle of every conversion in a queue. The monitor samples on the falling clock edge and compares the cycle and the word at each `done`, and any unexpected pulse is flagged. The stimulus checks the other outputs on the cycle just before and the cycle of each due edge.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_SLEEP = 2'd2,
        ST_WAKE  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/cnv_pin_sync.sv
module cnv_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic level_hi,
    output logic fell
);

    logic [STAGES-1:0] chain;
    logic              prev;

    // Synchroniser chain, idle-high after reset
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= 1'b1;
                else        chain[0] <= pin_n;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= 1'b1;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= chain[STAGES-1];
    end

    assign level_hi = chain[STAGES-1];
    assign fell     = prev & ~chain[STAGES-1];

    // R2
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fell |=> !fell);

endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R4
    timer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));

    // R4
    timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/result_capture.sv
module result_capture #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] result,
    output logic              done
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= capture;
            if (capture) result <= din;
        end
    end

    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result != $past(result)) |-> done);

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
    import conv_seq_pkg::*;
#(
    parameter int DATA_W       = 10,
    parameter int CONV_CYCLES  = 115,
    parameter int PWRUP_CYCLES = 75,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnv_n,
    input  logic              sw_start,
    input  logic              sw_sleep,
    input  logic              ext_ref_sel,
    input  logic [DATA_W-1:0] adc_data,
    output logic              hold_en,
    output logic              core_pwr,
    output logic              intref_pwr,
    output logic              busy,
    output logic              ready,
    output logic              done,
    output logic [DATA_W-1:0] result
);

    localparam int LONGEST = (CONV_CYCLES > PWRUP_CYCLES) ? CONV_CYCLES : PWRUP_CYCLES;
    localparam int TW      = $clog2(LONGEST + 1);
    localparam logic [TW-1:0] CONV_LD  = TW'(CONV_CYCLES - 1);
    localparam logic [TW-1:0] PWRUP_LD = TW'(PWRUP_CYCLES - 1);

    seq_state_e st, nxt;
    logic          pin_hi, pin_fell;
    logic          t_load, t_zero, eoc;
    logic [TW-1:0] t_val;
    logic          start_req;

    cnv_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_n    (cnv_n),
        .level_hi (pin_hi),
        .fell     (pin_fell)
    );

    phase_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    result_capture #(.DATA_W(DATA_W)) u_result (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (eoc),
        .din     (adc_data),
        .result  (result),
        .done    (done)
    );

    assign start_req = pin_fell | sw_start;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Next state and timer control
    always_comb begin
        nxt    = st;
        t_load = 1'b0;
        t_val  = '0;
        eoc    = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (start_req) begin
                    nxt    = ST_CONV;
                    t_load = 1'b1;
                    t_val  = CONV_LD;
                end
            end
            ST_CONV: begin
                if (t_zero) begin
                    eoc = 1'b1;
                    nxt = (!pin_hi || sw_sleep) ? ST_SLEEP : ST_IDLE;
                end
            end
            ST_SLEEP: begin
                if (pin_hi && !sw_sleep) begin
                    nxt    = ST_WAKE;
                    t_load = 1'b1;
                    t_val  = PWRUP_LD;
                end
            end
            ST_WAKE: begin
                if (t_zero) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        hold_en  = 1'b0;
        core_pwr = 1'b1;
        busy     = 1'b1;
        ready    = 1'b0;
        unique case (st)
            ST_IDLE: begin
                busy  = 1'b0;
                ready = 1'b1;
            end
            ST_CONV:  hold_en  = 1'b1;
            ST_SLEEP: core_pwr = 1'b0;
            ST_WAKE:  ;
            default:  ;
        endcase
        intref_pwr = core_pwr & ~ext_ref_sel;
    end

    // R4
    conv_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CONV && !t_zero) |=> (st == ST_CONV));

    // R7
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_pwr) |-> done);

    // R9
    wake_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_pwr) |-> (busy && !ready && !done));

    // R6
    busy_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAKE) |=> !hold_en);

endmodule

// File: tb/conv_sequencer_bench.sv
module conv_sequencer_bench;

    localparam int DW = 10;
    localparam int C  = 115;
    localparam int PU = 75;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cnv_n, sw_start, sw_sleep, ext_ref_sel;
    logic [DW-1:0] adc_data;
    logic          hold_en, core_pwr, intref_pwr, busy, ready, done;
    logic [DW-1:0] result;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        int            due;
        logic [DW-1:0] val;
    } exp_t;
    exp_t sb_q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    conv_sequencer #(
        .DATA_W(DW), .CONV_CYCLES(C), .PWRUP_CYCLES(PU), .SYNC_STAGES(2)
    ) u_conv_sequencer (
        .clk(clk), .rst_n(rst_n), .cnv_n(cnv_n), .sw_start(sw_start),
        .sw_sleep(sw_sleep), .ext_ref_sel(ext_ref_sel), .adc_data(adc_data),
        .hold_en(hold_en), .core_pwr(core_pwr), .intref_pwr(intref_pwr),
        .busy(busy), .ready(ready), .done(done), .result(result)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: got %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic to_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // Driver: software start; returns at the next falling edge
    task automatic sw_conv(input logic [DW-1:0] v, output int due);
        exp_t e;
        @(negedge clk);
        adc_data = v;
        sw_start = 1'b1;
        due      = cyc + 1 + C;
        e.due = due; e.val = v;
        sb_q.push_back(e);
        @(negedge clk);
        sw_start = 1'b0;
    endtask

    // Driver: pin start; pin stays low until the caller releases it
    task automatic pin_conv(input logic [DW-1:0] v, output int start_cyc, output int due);
        exp_t e;
        @(negedge clk);
        adc_data  = v;
        cnv_n     = 1'b0;
        start_cyc = cyc;
        due       = cyc + 3 + C;
        e.due = due; e.val = v;
        sb_q.push_back(e);
    endtask

    // Monitor: compares each done pulse against the scoreboard
    always @(negedge clk) begin
        if (rst_n === 1'b1 && done === 1'b1) begin
            if (sb_q.size() == 0) begin
                check("R6 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check("R4 done cycle", cyc, e.due);
                check("R4 result word", int'(result), int'(e.val));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int c, d, w, s;
        rst_n = 1'b0; cnv_n = 1'b1; sw_start = 1'b0; sw_sleep = 1'b0;
        ext_ref_sel = 1'b0; adc_data = '0;
        repeat (3) @(negedge clk);
        check("R1 ready in reset", int'(ready), 1);
        check("R1 core_pwr in reset", int'(core_pwr), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 hold_en", int'(hold_en), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 result", int'(result), 0);

        // R10 reference gating while idle
        check("R10 intref idle", int'(intref_pwr), 1);
        ext_ref_sel = 1'b1; @(negedge clk);
        check("R10 intref ext", int'(intref_pwr), 0);
        ext_ref_sel = 1'b0; @(negedge clk);

        // R3 software start, R6 requests while converting, R8 stay powered
        sw_conv(10'h2A5, d);
        check("R3 hold after strobe", int'(hold_en), 1);
        c = cyc;
        to_cyc(c + 5); sw_start = 1'b1; @(negedge clk); sw_start = 1'b0;
        cnv_n = 1'b0; repeat (3) @(negedge clk); cnv_n = 1'b1;
        adc_data = 10'h2A5;
        to_cyc(d - 1);
        check("R4 hold last cycle", int'(hold_en), 1);
        to_cyc(d);
        check("R4 hold released", int'(hold_en), 0);
        check("R8 stays powered", int'(core_pwr), 1);
        check("R8 back to ready", int'(ready), 1);
        adc_data = 10'h011;
        repeat (4) @(negedge clk);
        check("R5 result held", int'(result), 10'h2A5);

        // R2 pin start, R7 sleep by pin level, R6 ignored in sleep/wake, R9 wake
        pin_conv(10'h1C3, c, d);
        to_cyc(c + 2);
        check("R2 hold not yet", int'(hold_en), 0);
        to_cyc(c + 3);
        check("R2 hold after sync", int'(hold_en), 1);
        to_cyc(d);
        check("R7 core asleep", int'(core_pwr), 0);
        check("R10 intref asleep", int'(intref_pwr), 0);
        to_cyc(d + 3); sw_start = 1'b1; @(negedge clk); sw_start = 1'b0;
        to_cyc(d + 6);
        check("R6 no start in sleep", int'(hold_en), 0);
        check("R6 still asleep", int'(core_pwr), 0);
        @(negedge clk); cnv_n = 1'b1; w = cyc;
        to_cyc(w + 2);
        check("R9 not yet awake", int'(core_pwr), 0);
        to_cyc(w + 3);
        check("R9 core powered", int'(core_pwr), 1);
        check("R9 busy waking", int'(busy), 1);
        to_cyc(w + 10); sw_start = 1'b1; @(negedge clk); sw_start = 1'b0;
        to_cyc(w + 13);
        check("R6 no start in wake", int'(hold_en), 0);
        to_cyc(w + 2 + PU);
        check("R9 not ready early", int'(ready), 0);
        to_cyc(w + 3 + PU);
        check("R9 ready after delay", int'(ready), 1);

        // R11 sleep bit while idle, R8 sleep by software bit
        @(negedge clk); sw_sleep = 1'b1;
        repeat (20) @(negedge clk);
        check("R11 idle stays powered", int'(core_pwr), 1);
        check("R11 idle stays ready", int'(ready), 1);
        sw_conv(10'h3FF, d);
        to_cyc(d);
        check("R8 software sleep", int'(core_pwr), 0);
        to_cyc(d + 5);
        @(negedge clk); sw_sleep = 1'b0; s = cyc;
        to_cyc(s + 1);
        check("R9 software wake", int'(core_pwr), 1);
        check("R9 busy after software wake", int'(ready), 0);
        to_cyc(s + 1 + PU);
        check("R9 ready after software wake", int'(ready), 1);

        // R6 simultaneous strobe and pin fall give one conversion
        @(negedge clk);
        adc_data = 10'h000; sw_start = 1'b1; cnv_n = 1'b0;
        c = cyc; d = c + 1 + C;
        begin
            exp_t e;
            e.due = d; e.val = 10'h000;
            sb_q.push_back(e);
        end
        @(negedge clk); sw_start = 1'b0;
        to_cyc(c + 4); cnv_n = 1'b1;
        to_cyc(d);
        check("R6 single conversion powered", int'(core_pwr), 1);
        to_cyc(d + C + 10);
        check("R6 no pending conversions", sb_q.size(), 0);
        check("R4 result zero word", int'(result), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule